// File: doc/BRIEF.md
# Interval Timer with Selectable Count Source

The block is a 16-bit interval timer. A counter advances on a count tick and raises a one-cycle match pulse when it reaches a programmed compare value. On the next count tick it reloads to zero, so it repeats at a fixed interval.

The count tick comes from one of three kinds of source:
- a free-running divider of the system clock;
- rising edges of an external timer input;
- rising edges of a watch-timer tick.

A 3-bit select field and a 1-bit oscillator-mode bit choose the source together. Some of their combinations are not allowed. A disallowed combination freezes the counter and sets a sticky configuration error. Every source is turned into a single-cycle enable in the system clock domain, so the block needs no derived clock.

Top module: `interval_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `count` is 0, `match_irq` is 0 and `config_error` is 0.
- R2: Select 3'b001 with mode bit 1 advances the counter on every system clock.
- R3: Select 3'b010 ticks every 2 clocks with mode 1 and every 4 clocks with mode 0. A divide-by-D tick falls on the edge whose index since reset release, counted from 0, satisfies index mod D = D-1.
- R4: Select 3'b011 divides by 4 (mode 1) or 8 (mode 0). Select 3'b100 divides by 8 (mode 1) or 16 (mode 0). Both use the same phase rule as R3.
- R5: Select 3'b000 counts rising edges of `ext_in` for either mode. The edge passes through a two-flop synchronizer. A level first sampled high at edge n, after a low sample at edge n-1, advances the counter at edge n+2.
- R6: Select 3'b111 counts rising edges of `watch_in`, with the same synchronization and latency as R5.
- R7: The combinations 3'b001 with mode 0, 3'b101 and 3'b110 produce no ticks. The counter holds its value, no match pulse is raised, and `config_error` is set at the next edge.
- R8: `config_error` stays set once set, even after a legal selection returns. Only reset clears it.
- R9: On a tick, the counter loads 0 if it equals `cmp_val`, and otherwise increments. `match_irq` is high for exactly the cycle after a tick whose new count equals `cmp_val`. The interval is therefore `cmp_val`+1 ticks: 2 ticks at `cmp_val`=1.
- R10: With `cmp_val`=16'hFFFF, the counter runs through all 65536 values, so the match pulse repeats every 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External count input, asynchronous |
| watch_in | input | 1 | Watch-timer tick, asynchronous |
| clk_sel | input | 3 | Count-source select code |
| osc_mode | input | 1 | Oscillator mode bit, selects the divide ratio |
| cmp_val | input | 16 | Compare value |
| match_irq | output | 1 | One-cycle interrupt pulse on compare match |
| count | output | 16 | Current counter value |
| config_error | output | 1 | Sticky flag for a disallowed selection |

## Verification
A wrong prescaler phase or decode entry shows up on `count` within one divide period: the first step lands one or more cycles off the expected edge. A bad synchronizer depth shifts every externally driven step by a whole cycle, and the per-clock comparison catches it on the first edge. A wrong wrap or match decision shows on `match_irq` and on the reload to zero within `cmp_val`+1 ticks. A lost sticky bit shows in the first cycle after a legal selection is restored.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [2:0] {
    SRC_EXT   = 3'd0,
    SRC_DIV1  = 3'd1,
    SRC_DIV2  = 3'd2,
    SRC_DIV4  = 3'd3,
    SRC_DIV8  = 3'd4,
    SRC_DIV16 = 3'd5,
    SRC_WATCH = 3'd6,
    SRC_BAD   = 3'd7
  } src_e;

  // Map the select code and mode bit onto a count source.
  function automatic src_e src_decode(input logic [2:0] sel, input logic mode);
    src_e s;
    case (sel)
      3'b000:  s = SRC_EXT;
      3'b001:  s = mode ? SRC_DIV1 : SRC_BAD;
      3'b010:  s = mode ? SRC_DIV2 : SRC_DIV4;
      3'b011:  s = mode ? SRC_DIV4 : SRC_DIV8;
      3'b100:  s = mode ? SRC_DIV8 : SRC_DIV16;
      3'b111:  s = SRC_WATCH;
      default: s = SRC_BAD;
    endcase
    return s;
  endfunction

  // Value the counter takes on a tick.
  function automatic logic [15:0] cnt_next(input logic [15:0] cur, input logic [15:0] cmp);
    return (cur == cmp) ? 16'd0 : cur + 16'd1;
  endfunction

endpackage

// File: rtl/itmr_edge_sync.sv
module itmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LEN-2:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PRE_W:0] div_tick
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  assign div_tick[0] = 1'b1;
  for (genvar i = 1; i <= PRE_W; i++) begin : g_div
    assign div_tick[i] = &pre[i-1:0];
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             match_irq
);
  import itmr_pkg::*;
  logic [CNT_W-1:0] nxt;

  assign nxt = cnt_next(count, cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      match_irq <= 1'b0;
    end else if (tick) begin
      count     <= nxt;
      match_irq <= (nxt == cmp_val);
    end else begin
      match_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             watch_in,
  input  logic [2:0]       clk_sel,
  input  logic             osc_mode,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match_irq,
  output logic [CNT_W-1:0] count,
  output logic             config_error
);
  import itmr_pkg::*;

  logic           ext_rise, watch_rise, tick, src_bad;
  logic [PRE_W:0] div_tick;
  src_e           src;

  itmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .rise(ext_rise));

  itmr_edge_sync #(.STAGES(SYNC_STAGES)) u_watch_sync (
    .clk(clk), .rst_n(rst_n), .async_in(watch_in), .rise(watch_rise));

  itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick));

  assign src     = src_decode(clk_sel, osc_mode);
  assign src_bad = (src == SRC_BAD);

  always_comb begin
    case (src)
      SRC_EXT:   tick = ext_rise;
      SRC_DIV1:  tick = div_tick[0];
      SRC_DIV2:  tick = div_tick[1];
      SRC_DIV4:  tick = div_tick[2];
      SRC_DIV8:  tick = div_tick[3];
      SRC_DIV16: tick = div_tick[4];
      SRC_WATCH: tick = watch_rise;
      default:   tick = 1'b0;
    endcase
  end

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_val(cmp_val),
    .count(count), .match_irq(match_irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       config_error <= 1'b0;
    else if (src_bad) config_error <= 1'b1;
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             src_bad,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] count,
  input logic             match_irq,
  input logic             config_error
);
  p_hold_when_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    src_bad |=> ($stable(count) && !match_irq));

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    src_bad |=> config_error);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != cmp_val) |=> (count == CNT_W'($past(count) + 1'b1)));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == cmp_val) |=> (count == '0));

  p_idle_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(count) && !match_irq));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> (!match_irq || cmp_val == '0 || !$stable(cmp_val)));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .src_bad(src_bad),
  .cmp_val(cmp_val), .count(count), .match_irq(match_irq),
  .config_error(config_error));

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_in = 1'b0, watch_in = 1'b0;
  logic [2:0]  clk_sel = 3'b001;
  logic        osc_mode = 1'b1;
  logic [15:0] cmp_val = 16'd3;
  logic        match_irq, config_error;
  logic [15:0] count;

  int     n_vec = 0, n_bad = 0, cyc = 0;
  string  cur_req = "R1";
  bit     done = 0;

  // reference model state
  int m_count = 0, m_irq = 0, m_err = 0, k = 0;
  int eh[$];   // external input samples, newest first
  int wh[$];   // watch input samples, newest first

  always #4 clk = ~clk;   // 125 MHz

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .watch_in(watch_in),
    .clk_sel(clk_sel), .osc_mode(osc_mode), .cmp_val(cmp_val),
    .match_irq(match_irq), .count(count), .config_error(config_error));

  // divisor of the selected divided source; 0 = not a divider, -1 = illegal
  function automatic int divisor(input int sel, input int mode);
    if (sel == 0 || sel == 7) return 0;
    if (sel > 4 || (sel == 1 && mode == 0)) return -1;
    return 1 << (sel - 1 + (mode ? 0 : 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_irq = 0; m_err = 0; k = 0;
      eh = '{0, 0, 0}; wh = '{0, 0, 0};
    end else begin
      int d, t, nxt;
      d = divisor(clk_sel, osc_mode);
      if (d > 0)                 t = ((k % d) == d - 1);
      else if (d < 0)            t = 0;
      else if (clk_sel == 3'd0)  t = (eh[1] == 1 && eh[2] == 0);
      else                       t = (wh[1] == 1 && wh[2] == 0);
      if (d < 0) m_err = 1;
      if (t) begin
        nxt = (m_count == cmp_val) ? 0 : ((m_count + 1) % 65536);
        m_irq = (nxt == cmp_val);
        m_count = nxt;
      end else m_irq = 0;
      eh.push_front(ext_in);   void'(eh.pop_back());
      wh.push_front(watch_in); void'(wh.pop_back());
      k++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (count !== 16'(m_count) || match_irq !== 1'(m_irq) || config_error !== 1'(m_err)) begin
        n_bad++;
        $display("FAIL %s cyc %0d: count/irq/err act %0h/%0b/%0b exp %0h/%0b/%0b",
                 cur_req, cyc, count, match_irq, config_error, m_count, m_irq, m_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act timeout exp completion");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input string r, input logic [2:0] s, input logic m, input logic [15:0] c);
    cur_req = r; clk_sel = s; osc_mode = m; cmp_val = c;
  endtask

  task automatic pulse_in(input bit is_watch, input int hi, input int lo);
    if (is_watch) watch_in = 1'b1; else ext_in = 1'b1;
    run(hi);
    if (is_watch) watch_in = 1'b0; else ext_in = 1'b0;
    run(lo);
  endtask

  initial begin
    cur_req = "R1";
    run(5);
    rst_n = 1'b1;
    run(2);
    setup("R2", 3'b001, 1'b1, 16'd3);   run(40);
    setup("R3", 3'b010, 1'b1, 16'd5);   run(60);
    setup("R3", 3'b010, 1'b0, 16'd5);   run(80);
    setup("R4", 3'b011, 1'b1, 16'd2);   run(150);
    setup("R4", 3'b011, 1'b0, 16'd2);   run(150);
    setup("R4", 3'b100, 1'b1, 16'd2);   run(150);
    setup("R4", 3'b100, 1'b0, 16'd2);   run(150);
    setup("R9", 3'b001, 1'b1, 16'd1);   run(30);
    setup("R9", 3'b010, 1'b0, 16'd7);   run(70);
    setup("R5", 3'b000, 1'b0, 16'd4);
    for (int i = 0; i < 12; i++) pulse_in(0, 1 + (i % 3), 2 + (i % 4));
    setup("R5", 3'b000, 1'b1, 16'd4);
    for (int i = 0; i < 8; i++) pulse_in(0, 3, 1 + (i % 2));
    setup("R6", 3'b111, 1'b0, 16'd3);
    for (int i = 0; i < 10; i++) pulse_in(1, 2, 3);
    ext_in = 1'b1; run(4); ext_in = 1'b0;   // must not count while watch is chosen
    run(6);
    setup("R10", 3'b001, 1'b1, 16'hFFFF); run(131100);
    setup("R7", 3'b001, 1'b0, 16'd3);   run(20);
    setup("R7", 3'b101, 1'b1, 16'd3);   run(20);
    setup("R7", 3'b110, 1'b0, 16'd3);   run(20);
    setup("R8", 3'b001, 1'b1, 16'd3);   run(40);
    cur_req = "R1";
    rst_n = 1'b0; run(3);
    rst_n = 1'b1; run(2);
    setup("R2", 3'b001, 1'b1, 16'd9);   run(30);
    finish_run();
  end
endmodule